// File: doc/BRIEF.md
# 32/64-bit Logical and Arithmetic Shifter

A purely combinational shift unit for a 64-bit integer datapath. It performs left logical, right logical and right arithmetic shifts, each in a word form, which works on the low 32 bits of the source, and in a doubleword form, which works on all 64 bits. The unit has no rotate operation and does not touch condition codes.

The shift count comes from one of two places. It can be the low bits of a register operand, or it can be an immediate field from the instruction. The width mode sets how many of those bits count. The execute stage drives the source, both count candidates, the operation code and the width mode in the same cycle, and it takes the 64-bit result back in that cycle.

Top module: `shf64_unit`

## Requirements
- R1: With wide_i=1 and op_i=2'b00, result_o is data_i shifted left by the 6-bit count, and zeros fill from bit 0.
- R2: With wide_i=1 and op_i=2'b01, result_o is data_i shifted right by the 6-bit count, and zeros fill from bit 63.
- R3: With wide_i=1 and op_i=2'b11, result_o is data_i shifted right by the 6-bit count, and copies of data_i[63] fill from bit 63.
- R4: With wide_i=0, only the low 5 bits of the selected count are used, so count bit 5 has no effect on the result.
- R5: With wide_i=0 and a logical operation (op_i=2'b00, 2'b01 or 2'b10), result_o[31:0] is data_i[31:0] shifted by the 5-bit count, and result_o[63:32] is zero.
- R6: With wide_i=0 and op_i=2'b11, result_o[31:0] is data_i[31:0] shifted right, with copies of data_i[31] filling from bit 31, and result_o[63:32] repeats result_o[31].
- R7: With cnt_imm_sel_i=1 the count is imm_cnt_i. With cnt_imm_sel_i=0 the count is reg_cnt_i[5:0], and reg_cnt_i[63:6] has no effect.
- R8: An effective count of zero passes the operand through. In wide mode the output is data_i. In word mode it is data_i[31:0], zero-extended for the logical operations and sign-extended for op_i=2'b11.
- R9: op_i[0]=1 selects a right shift and op_i[0]=0 a left shift. op_i[1] selects arithmetic fill only for right shifts, so op_i=2'b10 behaves exactly like op_i=2'b00.
- R10: With wide_i=0, data_i[63:32] has no effect on result_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| data_i | input | 64 | Source operand |
| reg_cnt_i | input | 64 | Register operand that supplies a count; only its low bits are used |
| imm_cnt_i | input | 6 | Immediate count field |
| cnt_imm_sel_i | input | 1 | 1 selects the immediate count, 0 selects the register count |
| op_i | input | 2 | Bit 0 selects right, bit 1 selects arithmetic (right shifts only) |
| wide_i | input | 1 | 1 selects the 64-bit form, 0 selects the 32-bit form |
| result_o | output | 64 | Shifted result |

## Verification
The unit holds no state, so a faulty internal signal shows at result_o in the same cycle as the stimulus that exposes it. A wrong stage enable in the log shifter corrupts every count that has that bit set. A wrong fill bit shows up only on right shifts of negative operands. A missing word-mode mask shows up as nonzero upper bits on word left shifts. For these reasons the stimulus covers every count value, both signs in each width, and deliberately sets the count bits and upper source bits that should be ignored.

// File: rtl/shf_pkg.sv
package shf_pkg;
  localparam int unsigned SHF_DATA_W = 64;

  typedef enum logic [1:0] {
    SHF_LL  = 2'b00,
    SHF_RL  = 2'b01,
    SHF_LL2 = 2'b10,
    SHF_RA  = 2'b11
  } shf_op_e;

  typedef struct packed {
    logic right;
    logic arith;
  } shf_ctl_t;

  function automatic shf_ctl_t shf_decode(input logic [1:0] op);
    shf_ctl_t c;
    c.right = op[0];
    c.arith = op[0] & op[1];
    return c;
  endfunction
endpackage

// File: rtl/shf_cnt_sel.sv
module shf_cnt_sel #(
  parameter int unsigned CNT_W = 6
) (
  input  logic [CNT_W-1:0] reg_cnt_i,
  input  logic [CNT_W-1:0] imm_cnt_i,
  input  logic             imm_sel_i,
  input  logic             wide_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] raw_cnt;
  logic [CNT_W-1:0] width_mask;

  assign raw_cnt = imm_sel_i ? imm_cnt_i : reg_cnt_i;

  // word mode drops the top count bit
  always_comb begin
    width_mask = '1;
    if (!wide_i) width_mask[CNT_W-1] = 1'b0;
  end

  assign cnt_o = raw_cnt & width_mask;
endmodule

// File: rtl/shf_log_core.sv
module shf_log_core #(
  parameter int unsigned DATA_W = 64,
  localparam int unsigned CNT_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] vec_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              fill_i,
  output logic [DATA_W-1:0] vec_o
);
  logic [DATA_W-1:0] stage [CNT_W+1];

  assign stage[0] = vec_i;

  for (genvar s = 0; s < CNT_W; s++) begin : g_stage
    localparam int unsigned SH = 1 << s;
    assign stage[s+1] = cnt_i[s] ? {{SH{fill_i}}, stage[s][DATA_W-1:SH]} : stage[s];
  end

  assign vec_o = stage[CNT_W];
endmodule

// File: rtl/shf_bit_rev.sv
module shf_bit_rev #(
  parameter int unsigned DATA_W = 64
) (
  input  logic              en_i,
  input  logic [DATA_W-1:0] vec_i,
  output logic [DATA_W-1:0] vec_o
);
  logic [DATA_W-1:0] flipped;

  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    assign flipped[b] = vec_i[DATA_W-1-b];
  end

  assign vec_o = en_i ? flipped : vec_i;
endmodule

// File: rtl/shf64_unit.sv
module shf64_unit #(
  parameter int unsigned DATA_W = shf_pkg::SHF_DATA_W,
  localparam int unsigned HALF_W = DATA_W / 2,
  localparam int unsigned CNT_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic [DATA_W-1:0] reg_cnt_i,
  input  logic [CNT_W-1:0]  imm_cnt_i,
  input  logic              cnt_imm_sel_i,
  input  logic [1:0]        op_i,
  input  logic              wide_i,
  output logic [DATA_W-1:0] result_o
);
  import shf_pkg::*;

  shf_ctl_t          ctl;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] opnd;
  logic [DATA_W-1:0] core_in;
  logic [DATA_W-1:0] core_out;
  logic [DATA_W-1:0] shifted;
  logic              fill;
  logic              unused_cnt_hi;

  assign ctl = shf_decode(op_i);
  assign unused_cnt_hi = ^reg_cnt_i[DATA_W-1:CNT_W];

  shf_cnt_sel #(.CNT_W(CNT_W)) u_cnt (
    .reg_cnt_i (reg_cnt_i[CNT_W-1:0]),
    .imm_cnt_i (imm_cnt_i),
    .imm_sel_i (cnt_imm_sel_i),
    .wide_i    (wide_i),
    .cnt_o     (cnt)
  );

  // word mode: extend low half so a full-width right shift yields the word result
  always_comb begin
    if (wide_i)         opnd = data_i;
    else if (ctl.arith) opnd = {{HALF_W{data_i[HALF_W-1]}}, data_i[HALF_W-1:0]};
    else                opnd = {{HALF_W{1'b0}}, data_i[HALF_W-1:0]};
  end

  assign fill = ctl.arith & opnd[DATA_W-1];

  // left shifts run through the right shifter between two reversals
  shf_bit_rev #(.DATA_W(DATA_W)) u_rev_in (
    .en_i  (~ctl.right),
    .vec_i (opnd),
    .vec_o (core_in)
  );

  shf_log_core #(.DATA_W(DATA_W)) u_core (
    .vec_i  (core_in),
    .cnt_i  (cnt),
    .fill_i (fill),
    .vec_o  (core_out)
  );

  shf_bit_rev #(.DATA_W(DATA_W)) u_rev_out (
    .en_i  (~ctl.right),
    .vec_i (core_out),
    .vec_o (shifted)
  );

  always_comb begin
    result_o = shifted;
    if (!wide_i && !ctl.arith) result_o[DATA_W-1:HALF_W] = '0;
  end
endmodule

// File: rtl/shf64_unit_chk.sv
module shf64_unit_chk #(
  parameter int unsigned DATA_W = 64,
  localparam int unsigned HALF_W = DATA_W / 2,
  localparam int unsigned CNT_W = $clog2(DATA_W)
) (
  input logic [DATA_W-1:0] data_i,
  input logic [DATA_W-1:0] reg_cnt_i,
  input logic [CNT_W-1:0]  imm_cnt_i,
  input logic              cnt_imm_sel_i,
  input logic [1:0]        op_i,
  input logic              wide_i,
  input logic [DATA_W-1:0] result_o
);
  logic [CNT_W-1:0] eff;
  logic             sra;

  always_comb begin
    eff = cnt_imm_sel_i ? imm_cnt_i : reg_cnt_i[CNT_W-1:0];
    if (!wide_i) eff[CNT_W-1] = 1'b0;
    sra = (op_i == 2'b11);
  end

  always_comb begin
    if (!wide_i && !sra)
      p_word_upper_zero_r5: assert (result_o[DATA_W-1:HALF_W] == '0)
        else $error("R5 upper word not zero");
    if (!wide_i && sra)
      p_word_sign_ext_r6: assert (result_o[DATA_W-1:HALF_W] == {HALF_W{result_o[HALF_W-1]}})
        else $error("R6 upper word not sign copy");
    if (wide_i && sra)
      p_wide_msb_keep_r3: assert (result_o[DATA_W-1] == data_i[DATA_W-1])
        else $error("R3 sign bit lost");
    if (wide_i && op_i == 2'b01 && eff != '0)
      p_wide_zero_fill_r2: assert (result_o[DATA_W-1] == 1'b0)
        else $error("R2 top bit not zero-filled");
    if (!op_i[0] && eff != '0)
      p_left_lsb_zero_r1: assert (result_o[0] == 1'b0)
        else $error("R1 low bit not zero-filled");
    if (eff == '0 && wide_i)
      p_zero_cnt_wide_r8: assert (result_o == data_i)
        else $error("R8 wide pass-through");
    if (eff == '0 && !wide_i)
      p_zero_cnt_word_r8: assert (result_o[HALF_W-1:0] == data_i[HALF_W-1:0])
        else $error("R8 word pass-through");
  end
endmodule

bind shf64_unit shf64_unit_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/tb_shf64_unit.sv
`timescale 1ns/1ps
module tb_shf64_unit;
  logic        clk = 1'b0;
  logic [63:0] data_i = '0;
  logic [63:0] reg_cnt_i = '0;
  logic [5:0]  imm_cnt_i = '0;
  logic        cnt_imm_sel_i = 1'b0;
  logic [1:0]  op_i = 2'b00;
  logic        wide_i = 1'b0;
  logic [63:0] result_o;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  shf64_unit dut (.*);

  function automatic logic [63:0] model(input logic [63:0] d, input logic [63:0] rc,
      input logic [5:0] ic, input logic isel, input logic [1:0] op, input logic wide);
    int amt;
    logic [31:0] w;
    logic [63:0] r;
    amt = isel ? int'(ic) : int'(rc[5:0]);
    if (!wide) amt = amt % 32;
    if (wide) begin
      if (!op[0])     r = d << amt;
      else if (op[1]) r = $signed(d) >>> amt;
      else            r = d >> amt;
    end else begin
      w = d[31:0];
      if (!op[0])     w = w << amt;
      else if (op[1]) w = $signed(w) >>> amt;
      else            w = w >> amt;
      r = (op == 2'b11) ? {{32{w[31]}}, w} : {32'h0, w};
    end
    return r;
  endfunction

  task automatic run(input logic [63:0] d, input logic [63:0] rc, input logic [5:0] ic,
      input logic isel, input logic [1:0] op, input logic wide, input string tag);
    logic [63:0] exp;
    @(posedge clk);
    #1;
    data_i = d; reg_cnt_i = rc; imm_cnt_i = ic;
    cnt_imm_sel_i = isel; op_i = op; wide_i = wide;
    exp = model(d, rc, ic, isel, op, wide);
    @(negedge clk);
    checks++;
    if (result_o !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, result_o, exp);
    end
  endtask

  // equality of two results, for no-effect requirements
  task automatic same(input logic [63:0] a, input logic [63:0] b, input string tag);
    checks++;
    if (a !== b) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, a, b);
    end
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R1..R10 act=hung exp=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [63:0] a, b;
    // idle state: all-zero inputs give zero (R8)
    @(negedge clk);
    checks++;
    if (result_o !== 64'h0) begin
      errors++;
      $display("FAIL R8 idle act=%h exp=%h", result_o, 64'h0);
    end
    run(64'h1, 64'd63, 6'd0, 1'b0, 2'b00, 1'b1, "R1 left 63");
    run(64'h8000_0000_0000_0000, 64'd63, 6'd0, 1'b0, 2'b01, 1'b1, "R2 srl 63");
    run(64'h8000_0000_0000_0000, 64'd4, 6'd0, 1'b0, 2'b11, 1'b1, "R3 sra neg");
    run(64'h4000_0000_0000_0000, 64'd62, 6'd0, 1'b0, 2'b11, 1'b1, "R3 sra pos");
    run(64'h0000_0000_0000_0001, 64'd33, 6'd0, 1'b0, 2'b00, 1'b0, "R4 cnt bit5");
    run(64'hFFFF_FFFF_FFFF_FFFF, 64'd4, 6'd0, 1'b0, 2'b00, 1'b0, "R5 word left");
    run(64'hFFFF_FFFF_FFFF_FFFF, 64'd31, 6'd0, 1'b0, 2'b01, 1'b0, "R5 word srl");
    run(64'h0000_0000_8000_0000, 64'd31, 6'd0, 1'b0, 2'b11, 1'b0, "R6 word sra neg");
    run(64'hFFFF_FFFF_7FFF_FFFF, 64'd4, 6'd0, 1'b0, 2'b11, 1'b0, "R6 word sra pos");
    run(64'h00FF, 64'd3, 6'd8, 1'b1, 2'b00, 1'b1, "R7 imm count");
    run(64'h00FF, 64'hFFFF_FFFF_FFFF_FF03, 6'd8, 1'b0, 2'b00, 1'b1, "R7 reg low bits");
    run(64'h1234_5678_8765_4321, 64'd0, 6'd0, 1'b0, 2'b11, 1'b0, "R8 word zero sra");
    run(64'h1234_5678_8765_4321, 64'd0, 6'd0, 1'b0, 2'b01, 1'b0, "R8 word zero srl");
    run(64'h1234_5678_8765_4321, 64'd64, 6'd0, 1'b0, 2'b11, 1'b1, "R8 wide zero");

    // R9: op 2'b10 equals op 2'b00
    run(64'hF0F0_1234_5678_9ABC, 64'd13, 6'd0, 1'b0, 2'b10, 1'b1, "R9 op10");
    a = result_o;
    run(64'hF0F0_1234_5678_9ABC, 64'd13, 6'd0, 1'b0, 2'b00, 1'b1, "R9 op00");
    b = result_o;
    same(a, b, "R9 op10 vs op00");

    // R10: upper source bits ignored in word mode
    run(64'h0000_0000_C000_0001, 64'd5, 6'd0, 1'b0, 2'b11, 1'b0, "R10 upper zero");
    a = result_o;
    run(64'hDEAD_BEEF_C000_0001, 64'd5, 6'd0, 1'b0, 2'b11, 1'b0, "R10 upper set");
    b = result_o;
    same(a, b, "R10 upper ignored");

    // R7: upper register count bits ignored
    run(64'h0123_4567_89AB_CDEF, 64'h0000_0000_0000_0007, 6'd0, 1'b0, 2'b01, 1'b1, "R7 reg clean");
    a = result_o;
    run(64'h0123_4567_89AB_CDEF, 64'hA5A5_A5A5_A5A5_A5C7, 6'd0, 1'b0, 2'b01, 1'b1, "R7 reg dirty");
    b = result_o;
    same(a, b, "R7 reg upper ignored");

    // every count, every op, both widths
    for (int w = 0; w < 2; w++)
      for (int op = 0; op < 4; op++)
        for (int c = 0; c < 64; c++)
          run(64'h9E37_79B9_7F4A_7C15, 64'(c), 6'(c), 1'(c & 1), 2'(op), 1'(w),
              w ? (op[0] ? (op[1] ? "R3 sweep" : "R2 sweep") : "R1 sweep")
                : (op == 3 ? "R6 sweep" : "R5 sweep"));

    for (int i = 0; i < 3000; i++) begin
      logic [1:0] op;
      logic wd;
      op = 2'($urandom);
      wd = 1'($urandom);
      run({$urandom, $urandom}, {$urandom, $urandom}, 6'($urandom), 1'($urandom), op, wd,
          wd ? (op[0] ? (op[1] ? "R3 rand" : "R2 rand") : "R1 rand")
             : (op == 2'b11 ? "R6 rand" : "R4 rand"));
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule